// File: doc/BRIEF.md
# Register Hazard Forward and Stall Unit

This block sits beside the execute stage of a five-stage in-order pipeline (fetch, decode and operand read, execute, memory, write-back). It compares the destination register of each older instruction in the execute, memory and write-back stages with the source registers of the younger instructions. From that comparison it picks the operands the ALU actually uses, and it decides when the front of the pipe must wait. Registers are written only in write-back and data memory is touched only in the memory stage, so the only hazards it resolves are read-after-write hazards on registers.

When forwarding is enabled, an ALU instruction in execute can take the result held in the memory stage or in the write-back stage in place of its staged operand. The memory-stage result is younger, so it wins when both match. A loaded value is not in hand until write-back. An ALU instruction that sits directly behind a load and reads its destination therefore holds fetch and decode for one cycle, and a nop goes into execute. When forwarding is disabled by parameter, the operands always pass straight through. In that case any ALU instruction in decode that reads a register still being produced in execute, memory or write-back holds the front of the pipe. The unit is purely combinational. Its outputs feed the ALU input multiplexers, the clock enables of the fetch and decode registers, and the opcode clear of the execute register.

Top module: `hz_forward_stall`

## Requirements
- R1: With every class flag low (no ALU or load instruction in any stage), all three stall outputs are low, `alu_x` equals `s3_x` and `alu_y` equals `s3_y`.
- R2: When `s3_alu` is low, `alu_x` equals `s3_x` and `alu_y` equals `s3_y`, whatever the register fields and results are.
- R3: With `FWD_EN=1` and `s3_alu` high, `alu_x` is `s4_z` if `s4_alu` is high and `s4_ra` equals `s3_rb`. Otherwise it is `s5_z` if (`s5_alu` or `s5_load`) is high and `s5_ra` equals `s3_rb`. Otherwise it is `s3_x`.
- R4: With `FWD_EN=1`, `alu_y` follows the rule of R3 with `s3_rc` in place of `s3_rb` and `s3_y` as the fallback, but only while `s3_imm` is low. While `s3_imm` is high, `alu_y` equals `s3_y`.
- R5: When the memory-stage and write-back-stage destinations both match a source field, the memory-stage result `s4_z` is the one selected.
- R6: A load in the memory stage (`s4_load` high, `s4_alu` low) never supplies `s4_z` to an operand, even when its destination matches.
- R7: With `FWD_EN=1`, a stall is raised exactly when `s2_alu` and `s3_load` are high and `s3_ra` equals `s2_rb`, or equals `s2_rc` with `s2_imm` low. A matching ALU producer in any later stage raises no stall.
- R8: `hold_fetch`, `hold_decode` and `bubble_ex` are active high and are always equal.
- R9: With `FWD_EN=0`, `alu_x` equals `s3_x` and `alu_y` equals `s3_y` always. A stall is raised exactly when `s2_alu` is high and some stage k in {3,4,5} with (`sk_alu` or `sk_load`) high has `sk_ra` equal to `s2_rb`, or equal to `s2_rc` with `s2_imm` low.
- R10: While `s2_imm` is high, a match on `s2_rc` raises no stall in either mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| s2_alu | input | 1 | Decode-stage instruction is an ALU operation |
| s2_imm | input | 1 | Decode-stage second operand is an immediate |
| s2_rb | input | RW | Decode-stage first source register |
| s2_rc | input | RW | Decode-stage second source register |
| s3_alu | input | 1 | Execute-stage instruction is an ALU operation |
| s3_load | input | 1 | Execute-stage instruction is a load |
| s3_imm | input | 1 | Execute-stage second operand is an immediate |
| s3_ra | input | RW | Execute-stage destination register |
| s3_rb | input | RW | Execute-stage first source register |
| s3_rc | input | RW | Execute-stage second source register |
| s3_x | input | DW | Staged first ALU operand |
| s3_y | input | DW | Staged second ALU operand |
| s4_alu | input | 1 | Memory-stage instruction is an ALU operation |
| s4_load | input | 1 | Memory-stage instruction is a load |
| s4_ra | input | RW | Memory-stage destination register |
| s4_z | input | DW | Memory-stage result register |
| s5_alu | input | 1 | Write-back instruction is an ALU operation |
| s5_load | input | 1 | Write-back instruction is a load |
| s5_ra | input | RW | Write-back destination register |
| s5_z | input | DW | Write-back value (ALU result or loaded data) |
| alu_x | output | DW | First ALU operand after forwarding |
| alu_y | output | DW | Second ALU operand after forwarding |
| hold_fetch | output | 1 | Freeze the fetch-stage registers |
| hold_decode | output | 1 | Freeze the decode-stage registers |
| bubble_ex | output | 1 | Force a nop into the execute stage |

## Verification
The bench aims at the double match where both later stages write the same source register. A unit with the priority reversed would hand the ALU a stale write-back value. It also puts a load in the memory stage with a matching destination, where a careless forward path would feed the load address in as data. Immediate forms receive matching `rc` fields in both decode and execute, so an unmasked compare would show up either as a spurious stall or as a replaced immediate. Finally, a load directly ahead of a dependent ALU instruction is set against an ALU producer at the same distance. The first must stall and the second must not, and the non-forwarding variant must stall at all three distances.

// File: rtl/hz_pkg.sv
package hz_pkg;

  // Where an ALU operand is taken from.
  typedef enum logic [1:0] {
    OPSRC_STAGED = 2'd0,
    OPSRC_NEAR   = 2'd1,
    OPSRC_FAR    = 2'd2
  } opsrc_e;

  // Number of older stages compared against the decode stage.
  localparam int unsigned PROD_STAGES = 3;

endpackage

// File: rtl/hz_src_select.sv
module hz_src_select
  import hz_pkg::*;
#(
  parameter int unsigned RW = 5
) (
  input  logic          use_en,
  input  logic [RW-1:0] src_reg,
  input  logic          near_wr,
  input  logic [RW-1:0] near_ra,
  input  logic          far_wr,
  input  logic [RW-1:0] far_ra,
  output opsrc_e        sel
);

  logic near_hit;
  logic far_hit;

  assign near_hit = use_en && near_wr && (near_ra == src_reg);
  assign far_hit  = use_en && far_wr  && (far_ra  == src_reg);

  // The younger (memory-stage) result wins over write-back.
  always_comb begin
    if (near_hit)     sel = OPSRC_NEAR;
    else if (far_hit) sel = OPSRC_FAR;
    else              sel = OPSRC_STAGED;
  end

endmodule

// File: rtl/hz_operand_mux.sv
module hz_operand_mux
  import hz_pkg::*;
#(
  parameter int unsigned DW = 32
) (
  input  opsrc_e        sel,
  input  logic [DW-1:0] staged,
  input  logic [DW-1:0] near_val,
  input  logic [DW-1:0] far_val,
  output logic [DW-1:0] operand
);

  always_comb begin
    unique case (sel)
      OPSRC_NEAR: operand = near_val;
      OPSRC_FAR:  operand = far_val;
      default:    operand = staged;
    endcase
  end

endmodule

// File: rtl/hz_stall_detect.sv
module hz_stall_detect
  import hz_pkg::*;
#(
  parameter int unsigned RW     = 5,
  parameter bit          FWD_EN = 1'b1
) (
  input  logic                            cons_alu,
  input  logic                            cons_imm,
  input  logic [RW-1:0]                   cons_rb,
  input  logic [RW-1:0]                   cons_rc,
  input  logic                            ex_load,
  input  logic [PROD_STAGES-1:0]          prod_wr,
  input  logic [PROD_STAGES-1:0][RW-1:0]  prod_ra,
  output logic                            stall
);

  logic [PROD_STAGES-1:0] reg_hit;
  logic [PROD_STAGES-1:0] need;

  // Index 0 is the execute stage, 1 memory, 2 write-back.
  for (genvar k = 0; k < int'(PROD_STAGES); k++) begin : g_prod
    logic gate;
    assign reg_hit[k] = (prod_ra[k] == cons_rb) ||
                        (!cons_imm && (prod_ra[k] == cons_rc));
    if (k == 0) begin : g_near
      // With forwarding only a load right ahead cannot be served.
      assign gate = (FWD_EN != 1'b0) ? ex_load : prod_wr[k];
    end else begin : g_far
      assign gate = (FWD_EN != 1'b0) ? 1'b0 : prod_wr[k];
    end
    assign need[k] = gate && reg_hit[k];
  end

  assign stall = cons_alu && (|need);

endmodule

// File: rtl/hz_forward_stall.sv
module hz_forward_stall
  import hz_pkg::*;
#(
  parameter int unsigned DW     = 32,
  parameter int unsigned RW     = 5,
  parameter bit          FWD_EN = 1'b1
) (
  input  logic          s2_alu,
  input  logic          s2_imm,
  input  logic [RW-1:0] s2_rb,
  input  logic [RW-1:0] s2_rc,
  input  logic          s3_alu,
  input  logic          s3_load,
  input  logic          s3_imm,
  input  logic [RW-1:0] s3_ra,
  input  logic [RW-1:0] s3_rb,
  input  logic [RW-1:0] s3_rc,
  input  logic [DW-1:0] s3_x,
  input  logic [DW-1:0] s3_y,
  input  logic          s4_alu,
  input  logic          s4_load,
  input  logic [RW-1:0] s4_ra,
  input  logic [DW-1:0] s4_z,
  input  logic          s5_alu,
  input  logic          s5_load,
  input  logic [RW-1:0] s5_ra,
  input  logic [DW-1:0] s5_z,
  output logic [DW-1:0] alu_x,
  output logic [DW-1:0] alu_y,
  output logic          hold_fetch,
  output logic          hold_decode,
  output logic          bubble_ex
);

  localparam bit FWD_ON = (FWD_EN != 1'b0);

  // ---------------- forwarding into execute ----------------
  logic   fwd_x_en;
  logic   fwd_y_en;
  logic   near_wr;
  logic   far_wr;
  opsrc_e x_sel;
  opsrc_e y_sel;

  assign fwd_x_en = FWD_ON && s3_alu;
  assign fwd_y_en = FWD_ON && s3_alu && !s3_imm;
  // Memory-stage Z holds an address for a load, so only ALU results qualify.
  assign near_wr  = s4_alu;
  assign far_wr   = s5_alu || s5_load;

  hz_src_select #(.RW(RW)) x_sel_i (
    .use_en  (fwd_x_en),
    .src_reg (s3_rb),
    .near_wr (near_wr),
    .near_ra (s4_ra),
    .far_wr  (far_wr),
    .far_ra  (s5_ra),
    .sel     (x_sel)
  );

  hz_src_select #(.RW(RW)) y_sel_i (
    .use_en  (fwd_y_en),
    .src_reg (s3_rc),
    .near_wr (near_wr),
    .near_ra (s4_ra),
    .far_wr  (far_wr),
    .far_ra  (s5_ra),
    .sel     (y_sel)
  );

  hz_operand_mux #(.DW(DW)) x_mux_i (
    .sel      (x_sel),
    .staged   (s3_x),
    .near_val (s4_z),
    .far_val  (s5_z),
    .operand  (alu_x)
  );

  hz_operand_mux #(.DW(DW)) y_mux_i (
    .sel      (y_sel),
    .staged   (s3_y),
    .near_val (s4_z),
    .far_val  (s5_z),
    .operand  (alu_y)
  );

  // ---------------- stall of the front end ----------------
  logic [PROD_STAGES-1:0]         prod_wr;
  logic [PROD_STAGES-1:0][RW-1:0] prod_ra;
  logic                           stall;

  assign prod_wr = {s5_alu || s5_load, s4_alu || s4_load, s3_alu || s3_load};
  assign prod_ra = {s5_ra, s4_ra, s3_ra};

  hz_stall_detect #(.RW(RW), .FWD_EN(FWD_EN)) stall_i (
    .cons_alu (s2_alu),
    .cons_imm (s2_imm),
    .cons_rb  (s2_rb),
    .cons_rc  (s2_rc),
    .ex_load  (s3_load),
    .prod_wr  (prod_wr),
    .prod_ra  (prod_ra),
    .stall    (stall)
  );

  assign hold_fetch  = stall;
  assign hold_decode = stall;
  assign bubble_ex   = stall;

endmodule

// File: rtl/hz_forward_stall_chk.sv
module hz_forward_stall_chk #(
  parameter int unsigned DW     = 32,
  parameter int unsigned RW     = 5,
  parameter bit          FWD_EN = 1'b1
) (
  input logic          s2_alu,
  input logic          s2_imm,
  input logic [RW-1:0] s2_rb,
  input logic [RW-1:0] s2_rc,
  input logic          s3_alu,
  input logic          s3_load,
  input logic          s3_imm,
  input logic [RW-1:0] s3_ra,
  input logic [RW-1:0] s3_rb,
  input logic [RW-1:0] s3_rc,
  input logic [DW-1:0] s3_x,
  input logic [DW-1:0] s3_y,
  input logic          s4_alu,
  input logic          s4_load,
  input logic [RW-1:0] s4_ra,
  input logic [DW-1:0] s4_z,
  input logic          s5_alu,
  input logic          s5_load,
  input logic [RW-1:0] s5_ra,
  input logic [DW-1:0] s5_z,
  input logic [DW-1:0] alu_x,
  input logic [DW-1:0] alu_y,
  input logic          hold_fetch,
  input logic          hold_decode,
  input logic          bubble_ex
);

  always_comb begin
    if (!s3_alu)
      AST_PASS_NO_CONSUMER: assert (alu_x == s3_x && alu_y == s3_y); // R2
    if (s3_imm)
      AST_IMM_KEEPS_Y: assert (alu_y == s3_y); // R4
    AST_X_FROM_KNOWN_SRC: assert (alu_x == s3_x || alu_x == s4_z || alu_x == s5_z); // R3
    AST_HOLDS_AGREE: assert (hold_fetch == hold_decode && hold_decode == bubble_ex); // R8
    if (!s2_alu)
      AST_NO_STALL_IDLE: assert (!hold_fetch); // R1
  end

  if (FWD_EN != 1'b0) begin : g_fwd
    always_comb begin
      if (s3_alu && s4_alu && s4_ra == s3_rb)
        AST_NEAR_PRIORITY: assert (alu_x == s4_z); // R5
      if (s2_alu && s3_load && s3_ra == s2_rb)
        AST_LOAD_USE_STALL: assert (bubble_ex); // R7
      if (!s3_load)
        AST_NO_ALU_STALL: assert (!hold_decode); // R7
    end
  end else begin : g_nofwd
    always_comb begin
      AST_NOFWD_STAGED: assert (alu_x == s3_x && alu_y == s3_y); // R9
    end
  end

endmodule

bind hz_forward_stall hz_forward_stall_chk #(.DW(DW), .RW(RW), .FWD_EN(FWD_EN)) chk_i (.*);

// File: tb/hz_forward_stall_tb.sv
`timescale 1ns/1ps
module hz_forward_stall_tb_top;

  localparam int unsigned DW = 32;
  localparam int unsigned RW = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  logic          s2_alu, s2_imm, s3_alu, s3_load, s3_imm;
  logic          s4_alu, s4_load, s5_alu, s5_load;
  logic [RW-1:0] s2_rb, s2_rc, s3_ra, s3_rb, s3_rc, s4_ra, s5_ra;
  logic [DW-1:0] s3_x, s3_y, s4_z, s5_z;

  logic [DW-1:0] fx, fy, nx, ny;
  logic          f_hf, f_hd, f_bx, n_hf, n_hd, n_bx;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  hz_forward_stall #(.DW(DW), .RW(RW), .FWD_EN(1'b1)) dut_i (
    .s2_alu(s2_alu), .s2_imm(s2_imm), .s2_rb(s2_rb), .s2_rc(s2_rc),
    .s3_alu(s3_alu), .s3_load(s3_load), .s3_imm(s3_imm),
    .s3_ra(s3_ra), .s3_rb(s3_rb), .s3_rc(s3_rc), .s3_x(s3_x), .s3_y(s3_y),
    .s4_alu(s4_alu), .s4_load(s4_load), .s4_ra(s4_ra), .s4_z(s4_z),
    .s5_alu(s5_alu), .s5_load(s5_load), .s5_ra(s5_ra), .s5_z(s5_z),
    .alu_x(fx), .alu_y(fy), .hold_fetch(f_hf), .hold_decode(f_hd), .bubble_ex(f_bx)
  );

  hz_forward_stall #(.DW(DW), .RW(RW), .FWD_EN(1'b0)) dut_nf_i (
    .s2_alu(s2_alu), .s2_imm(s2_imm), .s2_rb(s2_rb), .s2_rc(s2_rc),
    .s3_alu(s3_alu), .s3_load(s3_load), .s3_imm(s3_imm),
    .s3_ra(s3_ra), .s3_rb(s3_rb), .s3_rc(s3_rc), .s3_x(s3_x), .s3_y(s3_y),
    .s4_alu(s4_alu), .s4_load(s4_load), .s4_ra(s4_ra), .s4_z(s4_z),
    .s5_alu(s5_alu), .s5_load(s5_load), .s5_ra(s5_ra), .s5_z(s5_z),
    .alu_x(nx), .alu_y(ny), .hold_fetch(n_hf), .hold_decode(n_hd), .bubble_ex(n_bx)
  );

  // ---------- reference model from the requirements ----------
  function automatic logic [DW-1:0] exp_fwd(input logic en, input logic [RW-1:0] src,
                                            input logic [DW-1:0] staged);
    if (en && s4_alu && s4_ra == src) return s4_z;
    if (en && (s5_alu || s5_load) && s5_ra == src) return s5_z;
    return staged;
  endfunction

  function automatic logic hit2(input logic [RW-1:0] ra);
    return (ra == s2_rb) || (!s2_imm && ra == s2_rc);
  endfunction

  function automatic logic exp_stall_fwd();
    return s2_alu && s3_load && hit2(s3_ra);
  endfunction

  function automatic logic exp_stall_nf();
    return s2_alu && (((s3_alu || s3_load) && hit2(s3_ra)) ||
                      ((s4_alu || s4_load) && hit2(s4_ra)) ||
                      ((s5_alu || s5_load) && hit2(s5_ra)));
  endfunction

  task automatic chk(input string req, input string what, input logic [DW-1:0] act,
                     input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic check_all(input string tag);
    logic sf, sn;
    sf = exp_stall_fwd();
    sn = exp_stall_nf();
    chk("R3", {tag, " fwd alu_x"}, fx, exp_fwd(s3_alu, s3_rb, s3_x));
    chk("R4", {tag, " fwd alu_y"}, fy, exp_fwd(s3_alu && !s3_imm, s3_rc, s3_y));
    chk("R7", {tag, " fwd bubble_ex"}, {31'd0, f_bx}, {31'd0, sf});
    chk("R8", {tag, " fwd hold_fetch"}, {31'd0, f_hf}, {31'd0, sf});
    chk("R8", {tag, " fwd hold_decode"}, {31'd0, f_hd}, {31'd0, sf});
    chk("R9", {tag, " nofwd alu_x"}, nx, s3_x);
    chk("R9", {tag, " nofwd alu_y"}, ny, s3_y);
    chk("R9", {tag, " nofwd stall"}, {29'd0, n_hf, n_hd, n_bx}, {29'd0, sn, sn, sn});
  endtask

  task automatic clear_all();
    {s2_alu, s2_imm, s3_alu, s3_load, s3_imm, s4_alu, s4_load, s5_alu, s5_load} = '0;
    s2_rb = '0; s2_rc = '0; s3_ra = '0; s3_rb = '0; s3_rc = '0; s4_ra = '0; s5_ra = '0;
    s3_x = 32'h1111_1111; s3_y = 32'h2222_2222;
    s4_z = 32'h4444_4444; s5_z = 32'h5555_5555;
  endtask

  task automatic step(input string tag);
    @(negedge clk);
    check_all(tag);
    @(posedge clk);
    #0.5;
  endtask

  // ---------- watchdog ----------
  initial begin
    for (int c = 0; c < 100000; c++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h0C0FFEE5));
    clear_all();
    repeat (2) @(posedge clk);
    rst = 1'b0;
    #0.5;

    // R1: idle state, nothing in flight
    @(negedge clk);
    chk("R1", "idle alu_x", fx, s3_x);
    chk("R1", "idle alu_y", fy, s3_y);
    chk("R1", "idle stall", {31'd0, f_hf | f_hd | f_bx | n_hf | n_hd | n_bx}, 32'd0);
    @(posedge clk); #0.5;

    // R2: no ALU consumer in execute, every register field matching
    clear_all(); s4_alu = 1; s5_alu = 1; s4_ra = 3; s5_ra = 3; s3_rb = 3; s3_rc = 3;
    step("R2 passthrough");
    chk("R2", "passthrough alu_x", fx, s3_x);

    // R3: far forward to X only
    clear_all(); s3_alu = 1; s3_rb = 7; s3_rc = 8; s5_alu = 1; s5_ra = 7;
    step("R3 far to x");
    chk("R3", "far to x", fx, s5_z);

    // R5: both match, memory stage wins on X and Y
    clear_all(); s3_alu = 1; s3_rb = 9; s3_rc = 9; s4_alu = 1; s4_ra = 9; s5_alu = 1; s5_ra = 9;
    step("R5 double match");
    chk("R5", "priority alu_x", fx, s4_z);
    chk("R5", "priority alu_y", fy, s4_z);

    // R6: load in memory stage does not forward its address; load in write-back does
    clear_all(); s3_alu = 1; s3_rb = 4; s4_load = 1; s4_ra = 4;
    step("R6 load in mem");
    chk("R6", "load4 no forward", fx, s3_x);
    s5_load = 1; s5_ra = 4;
    step("R6 load in wb");
    chk("R6", "load5 forwards", fx, s5_z);

    // R4: immediate masks Y forwarding
    clear_all(); s3_alu = 1; s3_imm = 1; s3_rc = 2; s4_alu = 1; s4_ra = 2;
    step("R4 imm");
    chk("R4", "imm keeps y", fy, s3_y);

    // R7: load-use stalls, ALU-use at same distance does not
    clear_all(); s2_alu = 1; s2_rb = 6; s3_load = 1; s3_ra = 6;
    step("R7 load use");
    chk("R7", "load-use stall", {31'd0, f_bx}, 32'd1);
    s3_load = 0; s3_alu = 1;
    step("R7 alu use");
    chk("R7", "alu-use no stall", {31'd0, f_bx}, 32'd0);

    // R10: immediate masks rc compare in decode, both modes
    clear_all(); s2_alu = 1; s2_imm = 1; s2_rb = 1; s2_rc = 5; s3_load = 1; s3_ra = 5;
    s4_alu = 1; s4_ra = 5;
    step("R10 imm decode");
    chk("R10", "imm no stall", {30'd0, f_hf, n_hf}, 32'd0);

    // R9: non-forwarding stall at distances 4 and 5
    clear_all(); s2_alu = 1; s2_rc = 12; s4_alu = 1; s4_ra = 12;
    step("R9 dist4");
    chk("R9", "dist4 stall", {31'd0, n_bx}, 32'd1);
    clear_all(); s2_alu = 1; s2_rb = 13; s5_load = 1; s5_ra = 13;
    step("R9 dist5");
    chk("R9", "dist5 stall", {31'd0, n_bx}, 32'd1);

    // constrained random: small register space for frequent matches
    for (int i = 0; i < 600; i++) begin
      int unsigned c3, c4, c5;
      c3 = $urandom_range(0, 2); c4 = $urandom_range(0, 2); c5 = $urandom_range(0, 2);
      s2_alu = 1'($urandom_range(0, 1)); s2_imm = 1'($urandom_range(0, 1));
      s3_alu = (c3 == 1); s3_load = (c3 == 2); s3_imm = 1'($urandom_range(0, 1));
      s4_alu = (c4 == 1); s4_load = (c4 == 2);
      s5_alu = (c5 == 1); s5_load = (c5 == 2);
      s2_rb = RW'($urandom_range(0, 3)); s2_rc = RW'($urandom_range(0, 3));
      s3_ra = RW'($urandom_range(0, 3)); s3_rb = RW'($urandom_range(0, 3));
      s3_rc = RW'($urandom_range(0, 3)); s4_ra = RW'($urandom_range(0, 3));
      s5_ra = RW'($urandom_range(0, 3));
      s3_x = $urandom; s3_y = $urandom; s4_z = $urandom; s5_z = $urandom;
      step("random");
    end

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule